// File: doc/BRIEF.md
# Dual-Slot Card Status Change Interrupt Unit

This block watches the status pins of two card sockets and turns their activity into one interrupt request. Each socket supplies eight pins: two voltage-sense pins, write-protect, two card-detect pins, two battery-voltage pins and a ready pin. Every pin passes through a two-flop synchronizer. The block then keeps three 32-bit registers that both slots share. The first shows the synchronized pin levels. The second is a sticky status-change register that is cleared by writing ones. The third is an enable register that chooses which status bits may raise the interrupt. Slot A uses the upper 16 bits of each register and slot B uses the lower 16 bits, with the same layout in both halves.

The ready pin feeds four separate status sources: a low level, a high level, a rising edge and a falling edge. The two level sources follow the synchronized pin directly and cannot be cleared. All the other status sources are sticky and record any transition of their pin. Software writes the status-change and enable registers one slot at a time through per-slot write strobes, so it never needs a read-modify-write of the shared register. A registered card-present flag for each slot is high when both card-detect pins are low.

Top module: `card_status_irq`

## Requirements
- R1: Address 0 reads the synchronized pins. Slot A pin byte is at bits 31..24 and slot B at bits 15..8, in the order VS1, VS2, WP, CD2, CD1, BVD2, BVD1, RDY from high bit to low bit. On `card_pins_i` the byte for slot s is `[8*s+7:8*s]` in the same order, and slot 0 is slot A. All other bits read 0. Address 3 reads 0.
- R2: Address 1 is the status-change register. Any transition of a synchronized VS1, VS2, WP, CD2, CD1, BVD2 or BVD1 pin sets the status bit at the same position as that pin in the address-0 layout (bits 31..25 for slot A, 15..9 for slot B).
- R3: A rising edge of the synchronized ready pin sets bit 21 for slot A or bit 5 for slot B. A falling edge sets bit 20 for slot A or bit 4 for slot B.
- R4: A write to address 1 clears each status bit written as 1 in the halves whose slot strobe `wr_slot_i[s]` is high. Bits written as 0, and halves whose strobe is low, are left unchanged.
- R5: If a status bit is set by a pin edge in the same cycle that a write clears it, the bit stays set.
- R6: Bit 23 for slot A and bit 7 for slot B read as the inverted synchronized ready pin. Bits 22 and 6 read as the synchronized ready pin. These level bits cannot be cleared by a write.
- R7: Address 2 is the enable register. A write updates only the halves whose slot strobe is high. Only bits 15..4 of each half can be written; the rest read 0.
- R8: `irq_o` is a registered OR of (status AND enable) over all bits. It stays high until the sources are cleared or disabled.
- R9: `card_present_o[s]` is high exactly when the synchronized CD1 and CD2 pins of slot s are both low.
- R10: After reset every register, `irq_o` and `card_present_o` read 0. Pin levels present at reset do not produce status edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| card_pins_i | input | 16 | Raw socket pins, one byte per slot |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 2 | Write address: 1 = status-change, 2 = enable |
| wr_slot_i | input | 2 | Per-slot write strobe (bit 0 = slot A) |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address: 0 pins, 1 status, 2 enable |
| rd_data_o | output | 32 | Registered read data, one cycle after the address |
| irq_o | output | 1 | Interrupt request |
| card_present_o | output | 2 | Card present per slot |

## Verification
The bench builds the block with its default of two slots, so both halves of every shared register are in use. This lets it check that a strobed write to one slot leaves the other half untouched. It also checks that edges on one slot's pins never show up in the other half. The timed clear that lands in the same cycle as a pin edge shows that the set takes priority.

// File: rtl/csi_pkg.sv
package csi_pkg;
  localparam int PIN_W  = 8;
  localparam int HALF_W = 16;

  // pin index inside one slot byte
  localparam int PIN_RDY = 0;
  localparam int PIN_CD1 = 3;
  localparam int PIN_CD2 = 4;

  // bit positions inside one 16-bit half
  localparam int HB_PIN_BASE = 8;
  localparam int HB_RLOW     = 7;
  localparam int HB_RHIGH    = 6;
  localparam int HB_RRISE    = 5;
  localparam int HB_RFALL    = 4;

  localparam logic [HALF_W-1:0] STICKY_MASK = 16'hFE30;
  localparam logic [HALF_W-1:0] IMPL_MASK   = 16'hFFF0;

  typedef enum logic [1:0] {
    ADDR_PINS = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_EN   = 2'd2,
    ADDR_NONE = 2'd3
  } csi_addr_e;
endpackage

// File: rtl/csi_sync.sv
module csi_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/csi_slot_detect.sv
module csi_slot_detect
  import csi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              edge_ok_i,
  input  logic [PIN_W-1:0]  pins_i,
  input  logic [HALF_W-1:0] clr_i,
  output logic [HALF_W-1:0] sticky_o,
  output logic [HALF_W-1:0] set_o,
  output logic [HALF_W-1:0] level_o,
  output logic              present_o
);
  logic [PIN_W-1:0]  prev_q;
  logic [PIN_W-1:0]  chg;
  logic [HALF_W-1:0] sticky_q;
  logic              present_q;

  assign chg = pins_i ^ prev_q;

  always_comb begin
    set_o = '0;
    if (edge_ok_i) begin
      for (int i = 1; i < PIN_W; i++) begin
        set_o[HB_PIN_BASE + i] = chg[i];
      end
      set_o[HB_RRISE] = chg[PIN_RDY] &  pins_i[PIN_RDY];
      set_o[HB_RFALL] = chg[PIN_RDY] & ~pins_i[PIN_RDY];
    end
  end

  always_comb begin
    level_o = '0;
    level_o[HB_RLOW]  = ~pins_i[PIN_RDY];
    level_o[HB_RHIGH] =  pins_i[PIN_RDY];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= '0;
      sticky_q  <= '0;
      present_q <= 1'b0;
    end else begin
      prev_q    <= pins_i;
      sticky_q  <= ((sticky_q & ~clr_i) | set_o) & STICKY_MASK;
      present_q <= ~pins_i[PIN_CD1] & ~pins_i[PIN_CD2];
    end
  end

  assign sticky_o  = sticky_q;
  assign present_o = present_q;
endmodule

// File: rtl/card_status_irq.sv
module card_status_irq
  import csi_pkg::*;
#(
  parameter int SLOTS = 2,
  localparam int REG_W = HALF_W * SLOTS,
  localparam int PINS_W = PIN_W * SLOTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PINS_W-1:0] card_pins_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [SLOTS-1:0]  wr_slot_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              irq_o,
  output logic [SLOTS-1:0]  card_present_o
);
  logic [PINS_W-1:0] pins_s;
  logic [1:0]        arm_q;
  logic              edge_ok;
  logic              wr_stat;
  logic              wr_en_reg;
  logic [REG_W-1:0]  stat_clr;
  logic [REG_W-1:0]  stat_set;
  logic [REG_W-1:0]  stat_sticky;
  logic [REG_W-1:0]  stat_level;
  logic [REG_W-1:0]  stat_view;
  logic [REG_W-1:0]  pin_view;
  logic [REG_W-1:0]  en_q;
  logic [REG_W-1:0]  en_next;
  logic [REG_W-1:0]  lane_mask;
  logic              irq_q;
  logic [REG_W-1:0]  rd_q;

  csi_sync #(.W(PINS_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (card_pins_i),
    .q_o (pins_s)
  );

  // hold off edge detection until the synchronizer and history hold real pin values
  always_ff @(posedge clk) begin
    if (rst)                arm_q <= '0;
    else if (arm_q != 2'd3) arm_q <= arm_q + 2'd1;
  end
  assign edge_ok = (arm_q == 2'd3);

  assign wr_stat   = wr_en_i && (wr_addr_i == ADDR_STAT);
  assign wr_en_reg = wr_en_i && (wr_addr_i == ADDR_EN);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int H = SLOTS - 1 - s;

    assign lane_mask[H*HALF_W +: HALF_W] = {HALF_W{wr_slot_i[s]}};
    assign stat_clr[H*HALF_W +: HALF_W]  =
      wr_data_i[H*HALF_W +: HALF_W] & {HALF_W{wr_stat && wr_slot_i[s]}};
    assign pin_view[H*HALF_W +: HALF_W]  =
      {pins_s[s*PIN_W +: PIN_W], {(HALF_W-PIN_W){1'b0}}};

    csi_slot_detect u_det (
      .clk       (clk),
      .rst       (rst),
      .edge_ok_i (edge_ok),
      .pins_i    (pins_s[s*PIN_W +: PIN_W]),
      .clr_i     (stat_clr[H*HALF_W +: HALF_W]),
      .sticky_o  (stat_sticky[H*HALF_W +: HALF_W]),
      .set_o     (stat_set[H*HALF_W +: HALF_W]),
      .level_o   (stat_level[H*HALF_W +: HALF_W]),
      .present_o (card_present_o[s])
    );
  end

  assign stat_view = stat_sticky | stat_level;

  always_comb begin
    en_next = en_q;
    if (wr_en_reg) begin
      en_next = (en_q & ~lane_mask) | (wr_data_i & lane_mask);
    end
    en_next = en_next & {SLOTS{IMPL_MASK}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      irq_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      en_q  <= en_next;
      irq_q <= |(stat_view & en_q);
      case (rd_addr_i)
        ADDR_PINS: rd_q <= pin_view;
        ADDR_STAT: rd_q <= stat_view;
        ADDR_EN:   rd_q <= en_q;
        default:   rd_q <= '0;
      endcase
    end
  end

  assign irq_o     = irq_q;
  assign rd_data_o = rd_q;
endmodule

// File: rtl/csi_checker.sv
module csi_checker #(
  parameter int REG_W = 32,
  parameter logic [REG_W-1:0] STICKY = 32'hFE30FE30
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i,
  input logic             irq_o,
  input logic [REG_W-1:0] stat_sticky,
  input logic [REG_W-1:0] stat_set,
  input logic [REG_W-1:0] stat_clr,
  input logic [REG_W-1:0] stat_view,
  input logic [REG_W-1:0] en_q
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R10: leaving reset, the interrupt and enable register are clear
  always_ff @(posedge clk) begin
    if (rst_q && !rst) begin
      p_reset_clear_r10: assert (!irq_o && en_q == '0)
        else $error("reset state not clear");
    end
  end

  // R8: an interrupt needs an enabled active source one cycle earlier
  p_irq_source_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|(stat_view & en_q)));

  // R5: an edge always lands in the sticky register, even against a clear
  p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
    |(stat_set & STICKY) |=>
      ((stat_sticky & $past(stat_set & STICKY)) == $past(stat_set & STICKY)));

  // R4: written ones clear bits that saw no edge
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_addr_i == 2'd1) |=>
      ((stat_sticky & $past(stat_clr & ~stat_set)) == '0));

  // R7: the enable register moves only on an enable write
  p_en_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(wr_en_i && wr_addr_i == 2'd2) |=> $stable(en_q));
endmodule

bind card_status_irq csi_checker #(
  .REG_W  (REG_W),
  .STICKY ({SLOTS{csi_pkg::STICKY_MASK}})
) u_csi_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .irq_o       (irq_o),
  .stat_sticky (stat_sticky),
  .stat_set    (stat_set),
  .stat_clr    (stat_clr),
  .stat_view   (stat_view),
  .en_q        (en_q)
);

// File: tb/card_status_irq_tb.sv
`timescale 1ns/1ps
module card_status_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] card_pins_i = 16'h1919;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = 2'd0;
  logic [1:0]  wr_slot_i = 2'b00;
  logic [31:0] wr_data_i = '0;
  logic [1:0]  rd_addr_i = 2'd0;
  logic [31:0] rd_data_o;
  logic        irq_o;
  logic [1:0]  card_present_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  card_status_irq dut_i (
    .clk            (clk),
    .rst            (rst),
    .card_pins_i    (card_pins_i),
    .wr_en_i        (wr_en_i),
    .wr_addr_i      (wr_addr_i),
    .wr_slot_i      (wr_slot_i),
    .wr_data_i      (wr_data_i),
    .rd_addr_i      (rd_addr_i),
    .rd_data_o      (rd_data_o),
    .irq_o          (irq_o),
    .card_present_o (card_present_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // pins: a = slot A byte, b = slot B byte
  task automatic set_pins(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    card_pins_i = {b, a};
    settle(6);
  endtask

  task automatic rd(input logic [1:0] addr, output logic [31:0] data);
    @(negedge clk);
    rd_addr_i = addr;
    @(posedge clk);
    @(negedge clk);
    data = rd_data_o;
  endtask

  task automatic wr(input logic [1:0] addr, input logic [31:0] data, input logic [1:0] slots);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = addr; wr_data_i = data; wr_slot_i = slots;
    @(negedge clk);
    wr_en_i = 1'b0; wr_slot_i = 2'b00;
    settle(2);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd1, d); check("R10 status after reset (levels only)", d, 32'h00400040);
    rd(2'd2, d); check("R10 enable after reset", d, 32'h0);
    check("R10 irq after reset", {31'b0, irq_o}, 32'h0);
    check("R10 present after reset", {30'b0, card_present_o}, 32'h0);
  endtask

  task automatic t_pins();
    logic [31:0] d;
    rd(2'd0, d); check("R1 pin register", d, 32'h19001900);
    rd(2'd3, d); check("R1 unused address", d, 32'h0);
  endtask

  task automatic t_edges();
    logic [31:0] d;
    set_pins(8'h39, 8'h11);
    rd(2'd1, d); check("R2 WP on A, CD1 on B", d, 32'h20400840);
    check("R9 B not present with CD2 high", {30'b0, card_present_o}, 32'h0);
    set_pins(8'h39, 8'h01);
    rd(2'd1, d); check("R2 CD2 on B", d, 32'h20401840);
    check("R9 B present", {30'b0, card_present_o}, 32'h2);
    rd(2'd0, d); check("R1 pins after change", d, 32'h39000100);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(2'd1, 32'h20000000, 2'b11);
    rd(2'd1, d); check("R4 clear A WP only", d, 32'h00401840);
    wr(2'd1, 32'h00001000, 2'b01);
    rd(2'd1, d); check("R4 strobe A does not clear B", d, 32'h00401840);
    wr(2'd1, 32'h00001000, 2'b10);
    rd(2'd1, d); check("R4 strobe B clears B CD2", d, 32'h00400840);
    wr(2'd1, 32'h0, 2'b11);
    rd(2'd1, d); check("R4 zeros leave bits", d, 32'h00400840);
  endtask

  task automatic t_ready();
    logic [31:0] d;
    set_pins(8'h38, 8'h01);
    rd(2'd1, d); check("R3 ready fall, R6 low level", d, 32'h00900840);
    wr(2'd1, 32'h00800000, 2'b11);
    rd(2'd1, d); check("R6 level bit not clearable", d, 32'h00900840);
    set_pins(8'h39, 8'h01);
    rd(2'd1, d); check("R3 ready rise, R6 high level", d, 32'h00700840);
    wr(2'd1, 32'hFFFFFFFF, 2'b11);
    rd(2'd1, d); check("R4 clear all sticky", d, 32'h00400040);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(2'd2, 32'hFFFFFFFF, 2'b01);
    rd(2'd2, d); check("R7 enable slot A half", d, 32'hFFF00000);
    wr(2'd2, 32'h00001237, 2'b10);
    rd(2'd2, d); check("R7 enable slot B half, low bits dropped", d, 32'hFFF01230);
    wr(2'd2, 32'h0, 2'b11);
    rd(2'd2, d); check("R7 enable cleared", d, 32'h0);
    check("R8 irq low with nothing enabled", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_irq();
    wr(2'd2, 32'h00400000, 2'b01);
    check("R8 irq from ready-high level", {31'b0, irq_o}, 32'h1);
    wr(2'd2, 32'h0, 2'b01);
    check("R8 irq drops when disabled", {31'b0, irq_o}, 32'h0);
    wr(2'd2, 32'h20000000, 2'b01);
    check("R8 irq low before edge", {31'b0, irq_o}, 32'h0);
    set_pins(8'h19, 8'h01);
    check("R8 irq on WP edge", {31'b0, irq_o}, 32'h1);
    settle(10);
    check("R8 irq holds", {31'b0, irq_o}, 32'h1);
    wr(2'd1, 32'h20000000, 2'b01);
    check("R8 irq drops on clear", {31'b0, irq_o}, 32'h0);
    wr(2'd2, 32'h0, 2'b11);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    set_pins(8'h19, 8'h81);
    rd(2'd1, d); check("R2 VS1 on B", d, 32'h00408040);
    // pin change before edge k; sticky update lands at edge k+2
    @(negedge clk);
    card_pins_i = {8'h01, 8'h19};
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 2'd1; wr_data_i = 32'h00008000; wr_slot_i = 2'b10;
    @(negedge clk);
    wr_en_i = 1'b0; wr_slot_i = 2'b00;
    settle(4);
    rd(2'd1, d); check("R5 edge wins over clear", d, 32'h00408040);
    wr(2'd1, 32'h00008000, 2'b10);
    rd(2'd1, d); check("R4 later clear works", d, 32'h00400040);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    settle(6);
    t_reset();
    t_pins();
    t_edges();
    t_clear();
    t_ready();
    t_enable();
    t_irq();
    t_set_wins();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule